// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog peripheral with a small register file on a single-cycle write bus and a combinational read port. A down-counter, clocked by a selectable fraction of the block clock, must be reloaded by software before it reaches zero. The first reload after reset starts the counter, and every reload needs an ordered two-write unlock on the kick register.

A reload is honoured only while the counter lies inside a programmable window, given as a fraction of the full period. A reload that falls outside the window, or a counter that runs out, raises a status flag. Depending on one bit in the response register, this either holds a level interrupt or emits a one-cycle reset request for the system reset controller. The configuration and response registers each take a single write between reset and the first reload. After that they stay locked until the next reset.

Register offsets: kick 0x0 (8 bit), config 0x2 (16 bit), status 0x4, response 0x6 (8 bit).

Top module: `wdog_window`

## Requirements
- R1: After reset, config reads 0x3353, response reads 0x0080, status reads 0, and irq and rst_req are low.
- R2: A reload happens only when a kick-register write of 0xFF directly follows a kick-register write of 0x00. 0xFF written without a directly preceding 0x00 does nothing. Any other value written after 0x00 cancels the pair.
- R3: Config bits [1:0] select the period P: 1024, 4096, 8192 or 16384 counts for 0, 1, 2 and 3. A reload loads P-1. The underflow flag sets on the P-th count after the reload.
- R4: Config bits [7:4] select the count rate: one count every 1, 4, 64, 128, 512 or 256 clocks for 0 to 5. Other codes count every clock.
- R5: A reload after the first is accepted only if counter ≤ S·P/4 and counter > E·P/4. S is config[13:12]+1. E is 3−config[9:8].
- R6: The first reload after reset is always accepted. A later out-of-window reload sets the refresh-error flag and leaves the counter untouched.
- R7: Config and response each accept one write, and only before the first reload. Writes after that are ignored.
- R8: Status bit 0 is the underflow flag and bit 1 the refresh-error flag. Writing 0 to a bit clears it and writing 1 keeps it. A flag that sets in the same cycle as a clear stays set.
- R9: With response bit 7 = 1, each underflow or refresh error gives a one-cycle rst_req in the following cycle. With bit 7 = 0, irq is high while either flag is set.
- R10: After an underflow the counter reloads to P-1 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt while a flag is set (interrupt mode) |
| rst_req | output | 1 | One-cycle reset request (reset mode) |

## Verification
An underflow can land in the same cycle as a reload or as a status clear. The bench times a kick pair so that its second write falls on the very count at which the counter reaches zero. Both flags must then be set, since a zero count is never in the window. It also times a status clear to hit the underflow edge, and the underflow flag must survive the clear. Random reload distances drawn from a fixed seed are judged against a window function computed in the bench.

// File: rtl/wdog_window.sv
module wdog_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int CW = 14;
  localparam int PW = 9;
  localparam int BW = CW + 3;
  typedef logic [BW-1:0] bw_t;
  typedef logic [CW-1:0] cnt_t;

  logic [15:0] cfg_q;
  logic [7:0]  resp_q;
  logic        cfg_used, resp_used, started, armed;
  cnt_t        cnt;
  logic [PW:0] pre;
  logic        uf_q, re_q, rst_req_q;

  logic [CW:0] period;
  logic [PW:0] div;

  always_comb begin
    case (cfg_q[1:0])
      2'd0: period = 15'd1024;
      2'd1: period = 15'd4096;
      2'd2: period = 15'd8192;
      default: period = 15'd16384;
    endcase
    case (cfg_q[7:4])
      4'd1: div = 10'd4;
      4'd2: div = 10'd64;
      4'd3: div = 10'd128;
      4'd4: div = 10'd512;
      4'd5: div = 10'd256;
      default: div = 10'd1;
    endcase
  end

  wire cnt_t reload  = cnt_t'(period - 15'd1);
  wire bw_t  quarter = bw_t'(period >> 2);
  wire bw_t  hi_b    = quarter * bw_t'(cfg_q[13:12]) + quarter;
  wire bw_t  lo_b    = quarter * bw_t'(2'd3 - cfg_q[9:8]);
  wire       in_win  = (bw_t'(cnt) <= hi_b) && (bw_t'(cnt) > lo_b);

  wire tick      = started && (pre == div - 10'd1);
  wire kick_wr   = bus_we && bus_addr == 3'd0;
  wire kick_fire = kick_wr && bus_wdata[7:0] == 8'hFF && armed;
  wire kick_ok   = kick_fire && (!started || in_win);
  wire kick_bad  = kick_fire && started && !in_win;
  wire uf_ev     = tick && cnt == '0;
  wire sts_wr    = bus_we && bus_addr == 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= 16'h3353;
      resp_q    <= 8'h80;
      cfg_used  <= 1'b0;
      resp_used <= 1'b0;
      started   <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      pre       <= '0;
      uf_q      <= 1'b0;
      re_q      <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (kick_wr) armed <= bus_wdata[7:0] == 8'h00;
      if (bus_we && bus_addr == 3'd2 && !cfg_used && !started) begin
        cfg_q    <= bus_wdata;
        cfg_used <= 1'b1;
      end
      if (bus_we && bus_addr == 3'd6 && !resp_used && !started) begin
        resp_q    <= bus_wdata[7:0];
        resp_used <= 1'b1;
      end
      if (kick_ok) begin
        started <= 1'b1;
        cnt     <= reload;
        pre     <= '0;
      end else if (started) begin
        pre <= tick ? '0 : pre + 10'd1;
        if (tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
      end
      uf_q      <= uf_ev    | (uf_q & (!sts_wr || bus_wdata[0]));
      re_q      <= kick_bad | (re_q & (!sts_wr || bus_wdata[1]));
      rst_req_q <= (uf_ev | kick_bad) & resp_q[7];
    end
  end

  assign irq     = ~resp_q[7] & (uf_q | re_q);
  assign rst_req = rst_req_q;

  always_comb begin
    case (bus_addr)
      3'd2: bus_rdata = cfg_q;
      3'd4: bus_rdata = {14'd0, re_q, uf_q};
      3'd6: bus_rdata = {8'd0, resp_q};
      default: bus_rdata = 16'd0;
    endcase
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> $stable(cfg_q) && $stable(resp_q));
  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !kick_ok) |=> cnt == $past(cnt) - 1'b1);
  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started);
  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> $past(armed));
endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq, rst_req;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  wdog_window u_wdog_window (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit win_ok(int c, int p, int ssel, int esel);
    return (c <= (ssel + 1) * p / 4) && (c > (3 - esel) * p / 4);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic kick();
    wr(3'd0, 16'h00); wr(3'd0, 16'hFF);
  endtask

  task automatic kick_at(int ed);
    while (cyc < ed - 2) @(negedge clk);
    kick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, e0, last_e, P;
    void'($urandom(32'h5eed));
    @(negedge clk);
    do_reset();
    rd(3'd2, v); check("R1 cfg", v, 16'h3353);
    rd(3'd6, v); check("R1 resp", v, 16'h0080);
    rd(3'd4, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0); check("R1 rst_req", rst_req, 0);
    wr(3'd0, 16'hFF); wr(3'd0, 16'h00); wr(3'd0, 16'h55); wr(3'd0, 16'hFF);
    wr(3'd2, 16'h1234);
    rd(3'd2, v); check("R2 bad unlock left config writable", v, 16'h1234);
    wr(3'd2, 16'h0000);
    rd(3'd2, v); check("R7 second config write ignored", v, 16'h1234);

    P = 1024;
    do_reset();
    wr(3'd2, 16'h1200); wr(3'd6, 16'h0000);
    kick(); e0 = cyc;
    wr(3'd2, 16'hFFFF); wr(3'd6, 16'h0080);
    rd(3'd2, v); check("R7 config locked", v, 16'h1200);
    rd(3'd6, v); check("R7 response locked", v, 0);
    while (cyc < e0 + P - 1) @(negedge clk);
    rd(3'd4, v); check("R3 no underflow before P", v, 0);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R8 set wins over clear", v, 1);
    check("R9 irq level", irq, 1);
    wr(3'd4, 16'h0003);
    rd(3'd4, v); check("R8 writing one keeps flag", v, 1);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R8 clear", v, 0);
    check("R9 irq low after clear", irq, 0);
    while (cyc < e0 + 2 * P - 1) @(negedge clk);
    rd(3'd4, v); check("R10 before second underflow", v, 0);
    @(negedge clk);
    rd(3'd4, v); check("R10 second underflow", v, 1);
    wr(3'd4, 16'h0000);
    last_e = e0 + 2 * P;
    kick_at(last_e + P);
    rd(3'd4, v); check("R6 R3 kick at zero count", v, 3);
    last_e = last_e + P;
    wr(3'd4, 16'h0000);
    for (int i = 0; i < 30; i++) begin
      int d, ed;
      bit ok;
      d = 1 + int'($urandom % P);
      ed = last_e + d;
      while (ed - 2 < cyc) begin last_e += P; ed = last_e + d; end
      kick_at(ed);
      ok = win_ok(P - d, P, 1, 2);
      rd(3'd4, v); check("R5 window decision", (v >> 1) & 1, ok ? 0 : 1);
      if (ok || d == P) last_e = ed;
      wr(3'd4, 16'h0000);
    end

    do_reset();
    wr(3'd2, 16'h0000);
    kick(); e0 = cyc;
    repeat (P - 1) @(negedge clk);
    check("R9 no early reset request", rst_req, 0);
    @(negedge clk);
    check("R9 reset request on underflow", rst_req, 1);
    check("R9 irq quiet in reset mode", irq, 0);
    @(negedge clk);
    check("R9 request lasts one cycle", rst_req, 0);
    kick();
    rd(3'd4, v); check("R6 empty window refresh error", v, 3);
    check("R9 reset request on refresh error", rst_req, 1);
    @(negedge clk);
    check("R9 single pulse", rst_req, 0);

    do_reset();
    wr(3'd2, 16'h0010); wr(3'd6, 16'h0000);
    kick(); e0 = cyc;
    while (cyc < e0 + 4 * P - 1) @(negedge clk);
    rd(3'd4, v); check("R4 divide by 4 early", v, 0);
    @(negedge clk);
    rd(3'd4, v); check("R4 divide by 4 underflow", v, 1);

    do_reset();
    wr(3'd2, 16'h3301); wr(3'd6, 16'h0000);
    kick(); e0 = cyc;
    while (cyc < e0 + 4095) @(negedge clk);
    rd(3'd4, v); check("R3 period 4096 early", v, 0);
    @(negedge clk);
    rd(3'd4, v); check("R3 period 4096 underflow", v, 1);
    finish_run();
  end
endmodule